// File: doc/BRIEF.md
# Paired Programmable Logic Cells with Shared Sequencer

This block holds two programmable logic cells, an even one and an odd one, and a sequencer that both of them feed. Each cell looks up its three select inputs in an eight-bit truth table, passes the result through a conditioning stage, and can then reduce it to a one-clock pulse on each rising edge. The conditioning stage can be bypassed, used as a two-stage synchronizer, or used as a glitch filter. The filter lets a new level through only after three samples in a row agree.

The sequencer reads the even cell as its first operand and the odd cell as its second. It can pass the even cell straight through, or act as a D flip-flop, a JK flip-flop, a D latch or an RS latch. Nothing conditions the sequencer output. A reset that lasts one clock on a set latch therefore shows up at the pair output as a low pulse exactly one clock wide. All state is cleared by a synchronous active-high reset.

Top module: `lcp_pair`

## Requirements
- R1: With conditioning bypassed (mode 0) and edge detection off, a cell output equals bit `{in[2],in[1],in[0]}` of its truth table, combinationally.
- R2: In synchronizer mode (mode 1), a cell output follows its table output 2 clock edges later.
- R3: In filter mode (mode 2), a steady new table level reaches the cell output 4 clock edges later. A change of the table output that lasts one or two clocks never reaches the cell output.
- R4: With edge detection on, a rising edge of the conditioned level gives a cell output high for exactly one clock. Otherwise the output stays low.
- R5: Sequencer code 0, and the unused codes 5 to 7, drive the pair output from the even cell output directly.
- R6: Code 1 (D flip-flop): at each clock edge where the odd cell is high, the pair output loads the even cell. When the odd cell is low, the output holds.
- R7: Code 2 (JK flip-flop, J = even, K = odd): at each edge, 10 sets the output, 01 clears it, 11 toggles it and 00 holds it.
- R8: Code 3 (D latch, data = even, gate = odd): while the odd cell is high, the pair output follows the even cell in the same cycle. While the odd cell is low, the output holds its last value.
- R9: Code 4 (RS latch, set = even, reset = odd): set alone drives the output to 1 at the next edge and reset alone drives it to 0. With both asserted, the output is unchanged.
- R10: In RS mode, a reset that lasts one clock followed at once by a set gives a low pulse exactly one clock wide at the pair output.
- R11: A synchronous reset clears the conditioning stages, the edge detectors and the sequencer state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| in_even | input | 3 | Select inputs of the even cell |
| in_odd | input | 3 | Select inputs of the odd cell |
| tt_even | input | 8 | Truth table of the even cell |
| tt_odd | input | 8 | Truth table of the odd cell |
| filt_even | input | 2 | Conditioning mode of the even cell (0 off, 1 sync, 2 filter) |
| filt_odd | input | 2 | Conditioning mode of the odd cell |
| edge_even | input | 1 | Rising-edge pulse enable, even cell |
| edge_odd | input | 1 | Rising-edge pulse enable, odd cell |
| seq_mode | input | 3 | Sequencer code (0 off, 1 DFF, 2 JK, 3 D latch, 4 RS) |
| cell_even_o | output | 1 | Even cell output |
| cell_odd_o | output | 1 | Odd cell output |
| pair_o | output | 1 | Sequencer output |

## Verification
The hardest case to reach from the ports is the runt pulse. The RS latch has to be set, then see reset for a single clock, then see set again on the very next clock, with no cycle in which both inputs are high. The stimulus gets there by making each truth table a copy of select bit 0, so that each cell follows one input pin with no delay. It then walks the set and reset inputs through that exact clock-by-clock sequence and samples the output after each edge. The filter's rejection of one-clock and two-clock glitches is handled the same way: the input is first held steady long enough to flush the chain.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  localparam int SEQ_W = 3;
  localparam int FLT_W = 2;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_OFF    = 3'd0,
    SEQ_DFF    = 3'd1,
    SEQ_JK     = 3'd2,
    SEQ_DLATCH = 3'd3,
    SEQ_RS     = 3'd4
  } seq_mode_e;

  typedef enum logic [FLT_W-1:0] {
    FLT_OFF    = 2'd0,
    FLT_SYNC   = 2'd1,
    FLT_GLITCH = 2'd2
  } flt_mode_e;

  function automatic logic jk_next(input logic q, input logic j, input logic k);
    case ({j, k})
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      2'b11:   return ~q;
      default: return q;
    endcase
  endfunction

  function automatic logic rs_next(input logic q, input logic s, input logic r);
    if (s && !r) return 1'b1;
    if (r && !s) return 1'b0;
    return q;
  endfunction
endpackage

// File: rtl/lcp_cell.sv
module lcp_cell
  import lcp_pkg::*;
#(
  parameter int NUM_IN     = 3,
  parameter int FILT_DEPTH = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        sel,
  input  logic [(1<<NUM_IN)-1:0]   tt,
  input  logic [FLT_W-1:0]         filt_mode,
  input  logic                     edge_en,
  output logic                     cell_o
);
  localparam int SHR_W = FILT_DEPTH - 1;

  logic             lut_v;
  logic [SHR_W-1:0] shr;
  logic             flt_q;
  logic             agree;
  logic             sync_v;
  logic             cond_v;
  logic             prev_q;
  logic             rise_v;

  assign lut_v  = tt[sel];
  assign agree  = (&shr) | ~(|shr);
  assign sync_v = shr[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shr   <= '0;
      flt_q <= 1'b0;
    end else begin
      shr   <= {shr[SHR_W-2:0], lut_v};
      if (agree) flt_q <= shr[SHR_W-1];
    end
  end

  always_comb begin
    case (flt_mode_e'(filt_mode))
      FLT_SYNC:   cond_v = sync_v;
      FLT_GLITCH: cond_v = flt_q;
      default:    cond_v = lut_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cond_v;
  end

  assign rise_v = cond_v & ~prev_q;
  assign cell_o = edge_en ? rise_v : cond_v;
endmodule

// File: rtl/lcp_seq.sv
module lcp_seq
  import lcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] mode,
  input  logic             a,
  input  logic             b,
  output logic             y
);
  logic q;
  logic q_nxt;

  always_comb begin
    y     = q;
    q_nxt = q;
    case (seq_mode_e'(mode))
      SEQ_DFF:    q_nxt = b ? a : q;
      SEQ_JK:     q_nxt = jk_next(q, a, b);
      SEQ_DLATCH: begin
        y     = b ? a : q;
        q_nxt = y;
      end
      SEQ_RS:     q_nxt = rs_next(q, a, b);
      default:    y = a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/lcp_pair.sv
module lcp_pair
  import lcp_pkg::*;
#(
  parameter int NUM_IN     = 3,
  parameter int FILT_DEPTH = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IN-1:0]      in_even,
  input  logic [NUM_IN-1:0]      in_odd,
  input  logic [(1<<NUM_IN)-1:0] tt_even,
  input  logic [(1<<NUM_IN)-1:0] tt_odd,
  input  logic [1:0]             filt_even,
  input  logic [1:0]             filt_odd,
  input  logic                   edge_even,
  input  logic                   edge_odd,
  input  logic [2:0]             seq_mode,
  output logic                   cell_even_o,
  output logic                   cell_odd_o,
  output logic                   pair_o
);
  localparam int TT_W   = 1 << NUM_IN;
  localparam int NCELLS = 2;

  logic [NUM_IN-1:0] sel_a [NCELLS];
  logic [TT_W-1:0]   tt_a  [NCELLS];
  logic [FLT_W-1:0]  fm_a  [NCELLS];
  logic [NCELLS-1:0] ed_a;
  logic [NCELLS-1:0] co;
  logic              even_v;
  logic              odd_v;

  assign sel_a[0] = in_even;
  assign sel_a[1] = in_odd;
  assign tt_a[0]  = tt_even;
  assign tt_a[1]  = tt_odd;
  assign fm_a[0]  = filt_even;
  assign fm_a[1]  = filt_odd;
  assign ed_a     = {edge_odd, edge_even};

  for (genvar g = 0; g < NCELLS; g++) begin : g_cell
    lcp_cell #(
      .NUM_IN    (NUM_IN),
      .FILT_DEPTH(FILT_DEPTH),
      .SYNC_DEPTH(SYNC_DEPTH)
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel_a[g]),
      .tt       (tt_a[g]),
      .filt_mode(fm_a[g]),
      .edge_en  (ed_a[g]),
      .cell_o   (co[g])
    );
  end

  assign even_v = co[0];
  assign odd_v  = co[1];

  lcp_seq u_seq (
    .clk (clk),
    .rst (rst),
    .mode(seq_mode),
    .a   (even_v),
    .b   (odd_v),
    .y   (pair_o)
  );

  assign cell_even_o = even_v;
  assign cell_odd_o  = odd_v;
endmodule

// File: rtl/lcp_pair_chk.sv
module lcp_pair_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] seq_mode,
  input logic       even_v,
  input logic       odd_v,
  input logic       edge_even,
  input logic       pair_o
);
  // R9
  rs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_mode == 3'd4 && even_v && odd_v) |=> (seq_mode != 3'd4 || pair_o == $past(pair_o)));

  // R9
  rs_set_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_mode == 3'd4 && even_v && !odd_v) |=> (seq_mode != 3'd4 || pair_o));

  // R7
  jk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_mode == 3'd2 && even_v && odd_v) |=> (seq_mode != 3'd2 || pair_o != $past(pair_o)));

  // R4
  edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_even && even_v) |=> (!edge_even || !even_v));

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_mode == 3'd0) |-> (pair_o == even_v));
endmodule

bind lcp_pair lcp_pair_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .seq_mode (seq_mode),
  .even_v   (even_v),
  .odd_v    (odd_v),
  .edge_even(edge_even),
  .pair_o   (pair_o)
);

// File: tb/lcp_pair_bench.sv
`timescale 1ns/1ps
module lcp_pair_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] in_even = '0, in_odd = '0;
  logic [7:0] tt_even = '0, tt_odd = '0;
  logic [1:0] filt_even = '0, filt_odd = '0;
  logic       edge_even = 1'b0, edge_odd = 1'b0;
  logic [2:0] seq_mode = '0;
  logic       cell_even_o, cell_odd_o, pair_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lcp_pair u_lcp_pair (
    .clk(clk), .rst(rst), .in_even(in_even), .in_odd(in_odd),
    .tt_even(tt_even), .tt_odd(tt_odd), .filt_even(filt_even), .filt_odd(filt_odd),
    .edge_even(edge_even), .edge_odd(edge_odd), .seq_mode(seq_mode),
    .cell_even_o(cell_even_o), .cell_odd_o(cell_odd_o), .pair_o(pair_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_ab(input logic a, input logic b);
    in_even = {2'b00, a};
    in_odd  = {2'b00, b};
    #0.5;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst = 1'b0;
    chk("R11 reset even", cell_even_o, 1'b0);
    chk("R11 reset odd", cell_odd_o, 1'b0);
    chk("R11 reset pair", pair_o, 1'b0);
  endtask

  task automatic t_lut();
    logic [7:0] te, to;
    te = 8'hB4;
    to = 8'h69;
    tt_even = te;
    tt_odd  = to;
    for (int i = 0; i < 8; i++) begin
      in_even = 3'(i);
      in_odd  = 3'(7 - i);
      #0.5;
      chk("R1 even lut", cell_even_o, te[i]);
      chk("R1 odd lut", cell_odd_o, to[7 - i]);
    end
  endtask

  task automatic t_sync();
    tt_even = 8'hAA; filt_even = 2'd1; in_even = 3'd0;
    repeat (4) tick();
    in_even = 3'd1;
    tick(); chk("R2 sync edge1", cell_even_o, 1'b0);
    tick(); chk("R2 sync edge2", cell_even_o, 1'b1);
    in_even = 3'd0;
    tick(); chk("R2 sync fall1", cell_even_o, 1'b1);
    tick(); chk("R2 sync fall2", cell_even_o, 1'b0);
  endtask

  task automatic t_filter();
    filt_even = 2'd2; in_even = 3'd0;
    repeat (5) tick();
    chk("R3 filter idle", cell_even_o, 1'b0);
    in_even = 3'd1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R3 filter rise", cell_even_o, (k == 4));
    end
    in_even = 3'd0; tick(); in_even = 3'd1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R3 filter 1-clk glitch", cell_even_o, 1'b1);
    end
    in_even = 3'd0; tick(); tick(); in_even = 3'd1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R3 filter 2-clk glitch", cell_even_o, 1'b1);
    end
  endtask

  task automatic t_edge();
    filt_even = 2'd0; edge_even = 1'b1; in_even = 3'd0;
    tick();
    in_even = 3'd1; #0.5;
    chk("R4 edge pulse", cell_even_o, 1'b1);
    tick(); chk("R4 edge after 1", cell_even_o, 1'b0);
    tick(); chk("R4 edge after 2", cell_even_o, 1'b0);
    in_even = 3'd0; tick();
    chk("R4 edge on fall", cell_even_o, 1'b0);
    in_even = 3'd1; #0.5;
    chk("R4 edge second", cell_even_o, 1'b1);
    tick();
    edge_even = 1'b0;
  endtask

  task automatic t_off();
    tt_even = 8'hAA; tt_odd = 8'hAA; seq_mode = 3'd0;
    set_ab(1'b1, 1'b0); chk("R5 off a=1", pair_o, 1'b1);
    set_ab(1'b0, 1'b1); chk("R5 off a=0", pair_o, 1'b0);
    seq_mode = 3'd6;
    set_ab(1'b1, 1'b1); chk("R5 code 6 a=1", pair_o, 1'b1);
    tick();
  endtask

  task automatic t_dff();
    seq_mode = 3'd1;
    set_ab(1'b1, 1'b1); tick(); chk("R6 dff load 1", pair_o, 1'b1);
    set_ab(1'b0, 1'b0); tick(); chk("R6 dff hold", pair_o, 1'b1);
    set_ab(1'b0, 1'b1); tick(); chk("R6 dff load 0", pair_o, 1'b0);
  endtask

  task automatic t_jk();
    seq_mode = 3'd2;
    set_ab(1'b1, 1'b0); tick(); chk("R7 jk set", pair_o, 1'b1);
    set_ab(1'b0, 1'b1); tick(); chk("R7 jk clear", pair_o, 1'b0);
    set_ab(1'b1, 1'b1); tick(); chk("R7 jk toggle1", pair_o, 1'b1);
    tick(); chk("R7 jk toggle2", pair_o, 1'b0);
    set_ab(1'b0, 1'b0); tick(); chk("R7 jk hold0", pair_o, 1'b0);
    set_ab(1'b1, 1'b0); tick();
    set_ab(1'b0, 1'b0); tick(); chk("R7 jk hold1", pair_o, 1'b1);
  endtask

  task automatic t_latch();
    seq_mode = 3'd3;
    set_ab(1'b0, 1'b1); chk("R8 latch open 0", pair_o, 1'b0);
    set_ab(1'b1, 1'b1); chk("R8 latch open 1", pair_o, 1'b1);
    tick();
    set_ab(1'b0, 1'b0); chk("R8 latch closed hold", pair_o, 1'b1);
    tick();
    set_ab(1'b1, 1'b0); chk("R8 latch closed still", pair_o, 1'b1);
    set_ab(1'b0, 1'b0); tick();
    chk("R8 latch closed edge", pair_o, 1'b1);
    set_ab(1'b0, 1'b1); chk("R8 latch reopen", pair_o, 1'b0);
    tick();
  endtask

  task automatic t_rs();
    seq_mode = 3'd4;
    set_ab(1'b0, 1'b1); tick(); chk("R9 rs reset", pair_o, 1'b0);
    set_ab(1'b1, 1'b0); tick(); chk("R9 rs set", pair_o, 1'b1);
    set_ab(1'b1, 1'b1); tick(); chk("R9 rs both hold 1", pair_o, 1'b1);
    set_ab(1'b0, 1'b1); tick(); chk("R9 rs reset again", pair_o, 1'b0);
    set_ab(1'b1, 1'b1); tick(); chk("R9 rs both hold 0", pair_o, 1'b0);
    // R10 runt: set, one clock of reset, set again
    set_ab(1'b1, 1'b0); tick();
    set_ab(1'b0, 1'b0); tick(); chk("R10 pre-runt high", pair_o, 1'b1);
    set_ab(1'b0, 1'b1); tick(); chk("R10 runt low", pair_o, 1'b0);
    set_ab(1'b1, 1'b0); tick(); chk("R10 runt back high", pair_o, 1'b1);
    set_ab(1'b0, 1'b0); tick(); chk("R10 stays high", pair_o, 1'b1);
  endtask

  task automatic t_midreset();
    seq_mode = 3'd4; filt_even = 2'd2;
    set_ab(1'b1, 1'b0);
    repeat (6) tick();
    chk("R11 pre-reset even", cell_even_o, 1'b1);
    chk("R11 pre-reset pair", pair_o, 1'b1);
    rst = 1'b1;
    set_ab(1'b0, 1'b0);
    tick();
    rst = 1'b0;
    chk("R11 filter cleared", cell_even_o, 1'b0);
    chk("R11 latch cleared", pair_o, 1'b0);
    tick();
    chk("R11 stays clear", pair_o, 1'b0);
    filt_even = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_lut();
    t_sync();
    t_filter();
    t_edge();
    t_off();
    t_dff();
    t_jk();
    t_latch();
    t_rs();
    t_midreset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule